// File: doc/BRIEF.md
# Interleaved Memory Block-Refill Controller

This block serves cache line refills from a main-memory model clocked on the memory bus. When a cache misses, it presents the line (block) address. The controller accepts the address when idle and spends one bus cycle driving it to memory. It then runs the word-wide bank accesses and returns the line's words on a lane-mapped transfer port, with a done pulse and the total penalty in bus cycles. All cycle counts are bus cycles. The memory bus runs slower than the processor, so this counter does not measure processor time.

The memory organisation is fixed at build time by one parameter. A narrow organisation has a single word-wide bank, so each word needs its own access and its own transfer. A wide organisation reads the whole line in one access and hands it over in one transfer. An interleaved organisation starts several banks in parallel with one shared access and then moves their words out one per bus cycle. Every access takes 15 bus cycles and every transfer takes one. The organisation therefore decides the miss penalty: 65, 17 or 20 cycles for a four-word line.

A memory word is modelled by a fixed function of its word address, so the returned data can be checked without a storage array.

Top module: `interleaved_refill_ctrl`

## Requirements
- R1: Once reset is released and before any request, `req_ready_o` is 1. `busy_o`, `bus_addr_valid_o`, `xfer_valid_o` and `done_o` are all 0.
- R2: A request is taken at a clock edge where `req_i` and `req_ready_o` are both 1. In the next cycle `bus_addr_valid_o` is 1 for exactly one cycle, and `bus_addr_o` equals the block address that was taken.
- R3: `done_o` is 1 for one cycle only, in the cycle of the last transfer. In that cycle `penalty_o` holds the number of cycles from the address cycle (counted as 1) up to and including that cycle.
- R4: Narrow organisation (`ORG`=0): each of the four words has its own 15-cycle access followed by a one-cycle transfer. The penalty is 65.
- R5: Wide organisation (`ORG`=1): one 15-cycle access follows the address cycle, and a single transfer then carries all four words. The penalty is 17.
- R6: Interleaved organisation (`ORG`=2, four banks): one shared 15-cycle access is followed by four consecutive single-word transfers. The penalty is 20.
- R7: Words are delivered in ascending offset order. During a transfer, bit w of `xfer_mask_o` is set exactly for each word offset w that is carried, and `xfer_idx_o` is the lowest carried offset. When no transfer is in progress the mask is 0.
- R8: Lane w of `xfer_data_o` (bits 32w+31 down to 32w) holds the word at word address {block address, w}. Its value is the low 32 bits of word_address × 0x9E3779B1, XORed with 0x5A5A5A5A. Lanes that are not carried read 0.
- R9: `busy_o` is 1 from the address cycle through the last-transfer cycle and 0 in the cycle after. `req_ready_o` is its inverse. The next request can be taken at the edge that ends the first idle cycle.
- R10: A request raised while the controller is busy has no effect. No address cycle follows it, and the penalty, order and data of the refill in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Refill request |
| req_blk_i | input | ADDR_W | Block address of the line to fetch |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| busy_o | output | 1 | Refill in progress |
| bus_addr_valid_o | output | 1 | Address cycle on the memory bus |
| bus_addr_o | output | ADDR_W | Block address driven to memory |
| xfer_valid_o | output | 1 | Transfer cycle |
| xfer_idx_o | output | IDX_W | Lowest word offset carried by this transfer |
| xfer_mask_o | output | WORDS | Word lanes carried by this transfer |
| xfer_data_o | output | WORDS*WORD_W | Line data, one lane per word offset |
| done_o | output | 1 | Last transfer of the refill |
| penalty_o | output | CYC_W | Bus cycles spent on the refill |

## Verification
The bench runs the three organisations side by side from one request stream. Each output is compared on every cycle with a schedule derived from the access and transfer costs. An off-by-one in the access counter shows up in all three modes, and the totals move away from 65, 17 and 20 by a multiple of the group count. A narrow design that does not reset its bank counter between words shortens every access after the first. An interleaved design that maps banks to the wrong lanes breaks the ascending mask, the index or the data lanes. Requests are also sent in the middle of a refill and on the done cycle, when they must be ignored, and then held continuously to test back-to-back acceptance. A design that takes them would either restart the address cycle or drop ready one cycle late. A block address of all ones checks that the word address does not lose its top bits.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ORG_NARROW      = 2'd0,
    ORG_WIDE        = 2'd1,
    ORG_INTERLEAVED = 2'd2
  } org_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ACCESS,
    PH_XFER
  } phase_e;

  localparam logic [63:0] FILL_MUL = 64'h0000_0000_9E37_79B1;
  localparam logic [63:0] FILL_XOR = 64'h0000_0000_5A5A_5A5A;

  // memory model content: a pure function of the word address
  function automatic logic [63:0] word_fill(input logic [63:0] waddr);
    logic [63:0] prod;
    prod = waddr * FILL_MUL;
    return {32'h0, prod[31:0]} ^ FILL_XOR;
  endfunction

endpackage

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter int unsigned GROUPS = 1,
  parameter int unsigned STEPS  = 4,
  parameter int unsigned GRP_W  = 1,
  parameter int unsigned STEP_W = 2,
  parameter int unsigned CYC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rdy_all_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              addr_o,
  output logic              access_o,
  output logic              xfer_o,
  output logic              last_o,
  output logic [GRP_W-1:0]  grp_o,
  output logic [STEP_W-1:0] step_o,
  output logic [CYC_W-1:0]  cyc_o
);

  phase_e            ph_q;
  logic [GRP_W-1:0]  grp_q;
  logic [STEP_W-1:0] step_q;
  logic [CYC_W-1:0]  cyc_q;
  logic              step_end;
  logic              grp_end;

  assign step_end = (step_q == STEP_W'(STEPS - 1));
  assign grp_end  = (grp_q == GRP_W'(GROUPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      grp_q  <= '0;
      step_q <= '0;
      cyc_q  <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (req_i) begin
            ph_q   <= PH_ADDR;
            grp_q  <= '0;
            step_q <= '0;
            cyc_q  <= CYC_W'(1);
          end
        end
        PH_ADDR: begin
          ph_q  <= PH_ACCESS;
          cyc_q <= cyc_q + CYC_W'(1);
        end
        PH_ACCESS: begin
          cyc_q <= cyc_q + CYC_W'(1);
          if (rdy_all_i) begin
            ph_q   <= PH_XFER;
            step_q <= '0;
          end
        end
        PH_XFER: begin
          cyc_q <= cyc_q + CYC_W'(1);
          if (step_end) begin
            step_q <= '0;
            if (grp_end) begin
              ph_q <= PH_IDLE;
            end else begin
              grp_q <= grp_q + GRP_W'(1);
              ph_q  <= PH_ACCESS;
            end
          end else begin
            step_q <= step_q + STEP_W'(1);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign ready_o  = (ph_q == PH_IDLE);
  assign busy_o   = (ph_q != PH_IDLE);
  assign addr_o   = (ph_q == PH_ADDR);
  assign access_o = (ph_q == PH_ACCESS);
  assign xfer_o   = (ph_q == PH_XFER);
  assign last_o   = xfer_o && step_end && grp_end;
  assign grp_o    = grp_q;
  assign step_o   = step_q;
  assign cyc_o    = cyc_q;

endmodule

// File: rtl/refill_bank.sv
module refill_bank
  import refill_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned WA_W    = 30,
  parameter int unsigned ACC_CYC = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              access_i,
  input  logic [WA_W-1:0]   waddr_i,
  output logic              rdy_o,
  output logic [WORD_W-1:0] data_o
);

  localparam int unsigned CNT_W = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] data_q;
  logic [63:0]       fill;

  assign fill  = word_fill(64'(waddr_i));
  assign rdy_o = access_i && (cnt_q == CNT_W'(ACC_CYC - 1));

  // counter restarts whenever the access strobe drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      if (!access_i || rdy_o) cnt_q <= '0;
      else                    cnt_q <= cnt_q + CNT_W'(1);
      if (rdy_o) data_q <= fill[WORD_W-1:0];
    end
  end

  assign data_o = data_q;

endmodule

// File: rtl/refill_lanes.sv
module refill_lanes #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned BANKS  = 4,
  parameter int unsigned LANES  = 1,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned GRP_W  = 1,
  parameter int unsigned STEP_W = 2
) (
  input  logic                    xfer_i,
  input  logic [GRP_W-1:0]        grp_i,
  input  logic [STEP_W-1:0]       step_i,
  input  logic [BANKS*WORD_W-1:0] bank_data_i,
  output logic [WORDS-1:0]        mask_o,
  output logic [WORDS*WORD_W-1:0] data_o
);

  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    localparam int unsigned LG = w / BANKS;
    localparam int unsigned LB = w % BANKS;
    localparam int unsigned LS = LB / LANES;
    logic hit;
    assign hit       = xfer_i && (grp_i == GRP_W'(LG)) && (step_i == STEP_W'(LS));
    assign mask_o[w] = hit;
    assign data_o[w*WORD_W +: WORD_W] = hit ? bank_data_i[LB*WORD_W +: WORD_W] : '0;
  end

endmodule

// File: rtl/interleaved_refill_ctrl.sv
module interleaved_refill_ctrl
  import refill_pkg::*;
#(
  parameter org_e        ORG      = ORG_INTERLEAVED,
  parameter int unsigned WORDS    = 4,
  parameter int unsigned IL_BANKS = 4,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned ADDR_W   = 28,
  parameter int unsigned ACC_CYC  = 15,
  parameter int unsigned CYC_W    = 16,
  localparam int unsigned IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [ADDR_W-1:0]       req_blk_i,
  output logic                    req_ready_o,
  output logic                    busy_o,
  output logic                    bus_addr_valid_o,
  output logic [ADDR_W-1:0]       bus_addr_o,
  output logic                    xfer_valid_o,
  output logic [IDX_W-1:0]        xfer_idx_o,
  output logic [WORDS-1:0]        xfer_mask_o,
  output logic [WORDS*WORD_W-1:0] xfer_data_o,
  output logic                    done_o,
  output logic [CYC_W-1:0]        penalty_o
);

  localparam int unsigned BANKS   = (ORG == ORG_NARROW) ? 1 :
                                    (ORG == ORG_WIDE)   ? WORDS : IL_BANKS;
  localparam int unsigned LANES   = (ORG == ORG_WIDE) ? WORDS : 1;
  localparam int unsigned GROUPS  = WORDS / BANKS;
  localparam int unsigned STEPS   = BANKS / LANES;
  localparam int unsigned GRP_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int unsigned STEP_W  = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int unsigned WA_W    = ADDR_W + IDX_W;
  localparam int unsigned PENALTY = 1 + GROUPS * (ACC_CYC + STEPS);

  logic                    ready;
  logic                    access;
  logic                    xfer;
  logic                    rdy_all;
  logic [GRP_W-1:0]        grp;
  logic [STEP_W-1:0]       step;
  logic [ADDR_W-1:0]       blk_q;
  logic [BANKS-1:0]        bank_rdy;
  logic [BANKS*WORD_W-1:0] bank_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              blk_q <= '0;
    else if (req_i && ready)  blk_q <= req_blk_i;
  end

  refill_seq #(
    .GROUPS (GROUPS),
    .STEPS  (STEPS),
    .GRP_W  (GRP_W),
    .STEP_W (STEP_W),
    .CYC_W  (CYC_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .rdy_all_i (rdy_all),
    .ready_o   (ready),
    .busy_o    (busy_o),
    .addr_o    (bus_addr_valid_o),
    .access_o  (access),
    .xfer_o    (xfer),
    .last_o    (done_o),
    .grp_o     (grp),
    .step_o    (step),
    .cyc_o     (penalty_o)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [IDX_W-1:0] off;
    assign off = IDX_W'(32'(grp) * BANKS + b);
    refill_bank #(
      .WORD_W  (WORD_W),
      .WA_W    (WA_W),
      .ACC_CYC (ACC_CYC)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .access_i (access),
      .waddr_i  ({blk_q, off}),
      .rdy_o    (bank_rdy[b]),
      .data_o   (bank_data[b*WORD_W +: WORD_W])
    );
  end

  assign rdy_all = &bank_rdy;

  refill_lanes #(
    .WORDS  (WORDS),
    .BANKS  (BANKS),
    .LANES  (LANES),
    .WORD_W (WORD_W),
    .GRP_W  (GRP_W),
    .STEP_W (STEP_W)
  ) u_lanes (
    .xfer_i      (xfer),
    .grp_i       (grp),
    .step_i      (step),
    .bank_data_i (bank_data),
    .mask_o      (xfer_mask_o),
    .data_o      (xfer_data_o)
  );

  assign req_ready_o  = ready;
  assign bus_addr_o   = blk_q;
  assign xfer_valid_o = xfer;
  assign xfer_idx_o   = IDX_W'(32'(grp) * BANKS + 32'(step) * LANES);

endmodule

// File: rtl/refill_checker.sv
module refill_checker #(
  parameter int unsigned WORDS   = 4,
  parameter int unsigned LANES   = 1,
  parameter int unsigned CYC_W   = 16,
  parameter int unsigned PENALTY = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             ready_i,
  input logic             busy_i,
  input logic             addr_v_i,
  input logic             xfer_i,
  input logic [WORDS-1:0] mask_i,
  input logic             done_i,
  input logic [CYC_W-1:0] penalty_i
);

  assert_addr_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_i) |=> (addr_v_i && busy_i));

  assert_addr_single_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_v_i |=> !addr_v_i);

  assert_done_in_xfer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> xfer_i);

  assert_done_penalty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (penalty_i == CYC_W'(PENALTY)));

  assert_lane_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |-> ($countones(mask_i) == LANES));

  assert_mask_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |-> (mask_i == '0));

  assert_idle_after_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!busy_i && ready_i));

  assert_no_xfer_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !xfer_i);

  assert_busy_req_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_i && !done_i) |=> !addr_v_i);

endmodule

bind interleaved_refill_ctrl refill_checker #(
  .WORDS   (WORDS),
  .LANES   (LANES),
  .CYC_W   (CYC_W),
  .PENALTY (PENALTY)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .ready_i   (req_ready_o),
  .busy_i    (busy_o),
  .addr_v_i  (bus_addr_valid_o),
  .xfer_i    (xfer_valid_o),
  .mask_i    (xfer_mask_o),
  .done_i    (done_o),
  .penalty_i (penalty_o)
);

// File: tb/interleaved_refill_ctrl_tb_top.sv
`timescale 1ns/1ps
module interleaved_refill_ctrl_tb_top;
  import refill_pkg::*;

  localparam int END_T     = 520;
  localparam int WDOG_CYC  = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0;
  logic [27:0] req_blk = '0;
  bit   run = 1'b0;

  always #2.5 clk = ~clk;

  logic         ready_w [3];
  logic         busy_w  [3];
  logic         addrv_w [3];
  logic [27:0]  addr_w  [3];
  logic         xv_w    [3];
  logic [1:0]   idx_w   [3];
  logic [3:0]   mask_w  [3];
  logic [127:0] data_w  [3];
  logic         done_w  [3];
  logic [15:0]  pen_w   [3];

  for (genvar m = 0; m < 3; m++) begin : g_mode
    localparam org_e MODE = (m == 0) ? ORG_NARROW : (m == 1) ? ORG_WIDE : ORG_INTERLEAVED;
    interleaved_refill_ctrl #(.ORG(MODE)) dut_i (
      .clk_i            (clk),
      .rst_ni           (rst_ni),
      .req_i            (req),
      .req_blk_i        (req_blk),
      .req_ready_o      (ready_w[m]),
      .busy_o           (busy_w[m]),
      .bus_addr_valid_o (addrv_w[m]),
      .bus_addr_o       (addr_w[m]),
      .xfer_valid_o     (xv_w[m]),
      .xfer_idx_o       (idx_w[m]),
      .xfer_mask_o      (mask_w[m]),
      .xfer_data_o      (data_w[m]),
      .done_o           (done_w[m]),
      .penalty_o        (pen_w[m])
    );
  end

  int nvec = 0;
  int nbad = 0;
  int tcnt = 0;
  int          mk   [3] = '{0, 0, 0};
  logic [27:0] mblk [3];
  bit          mign [3] = '{0, 0, 0};

  function automatic logic [31:0] fill(input logic [29:0] wa);
    logic [63:0] p;
    p = 64'(wa) * 64'h9E37_79B1;
    return p[31:0] ^ 32'h5A5A_5A5A;
  endfunction

  function automatic int n_banks(input int m); return (m == 0) ? 1 : 4; endfunction
  function automatic int n_lanes(input int m); return (m == 1) ? 4 : 1; endfunction
  function automatic int n_total(input int m);
    return 1 + (4 / n_banks(m)) * (15 + n_banks(m) / n_lanes(m));
  endfunction

  task automatic chk(input int m, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s org%0d t=%0d %s: actual %0h expected %0h", tag, m, tcnt, what, act, exp);
    end
  endtask

  task automatic check_mode(input int m);
    int k, b, l, s, n, j, g, r, idx;
    bit xv;
    logic [3:0] em;
    logic [127:0] ed;
    string mt, rt;
    int lit_pen;
    k = mk[m]; b = n_banks(m); l = n_lanes(m); s = b / l; n = n_total(m);
    mt = (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
    lit_pen = (m == 0) ? 65 : (m == 1) ? 17 : 20;
    rt = (tcnt < 3) ? "R1" : "R9";
    xv = 1'b0; em = '0; ed = '0; idx = 0;
    if (k >= 2) begin
      j = k - 2; g = j / (15 + s); r = j % (15 + s);
      if (r >= 15) begin
        xv = 1'b1;
        idx = g * b + (r - 15) * l;
        for (int q = 0; q < l; q++) begin
          em[idx + q] = 1'b1;
          ed[(idx + q) * 32 +: 32] = fill({mblk[m], 2'(idx + q)});
        end
      end
    end
    chk(m, rt, "ready", 128'(ready_w[m]), 128'(k == 0));
    chk(m, rt, "busy", 128'(busy_w[m]), 128'(k != 0));
    chk(m, (tcnt < 3) ? "R1" : "R2", "addr_valid", 128'(addrv_w[m]), 128'(k == 1));
    if (k == 1) chk(m, "R2", "bus_addr", 128'(addr_w[m]), 128'(mblk[m]));
    chk(m, (tcnt < 3) ? "R1" : mt, "xfer_valid", 128'(xv_w[m]), 128'(xv));
    chk(m, "R7", "mask", 128'(mask_w[m]), 128'(em));
    if (xv) chk(m, "R7", "idx", 128'(idx_w[m]), 128'(idx));
    chk(m, "R8", "data", data_w[m], ed);
    chk(m, (tcnt < 3) ? "R1" : "R3", "done", 128'(done_w[m]), 128'(xv && k == n));
    if (k == n) begin
      chk(m, mt, "penalty", 128'(pen_w[m]), 128'(lit_pen));
      chk(m, "R3", "penalty_formula", 128'(pen_w[m]), 128'(n));
      if (mign[m]) begin
        chk(m, "R10", "penalty_after_ignored_req", 128'(pen_w[m]), 128'(lit_pen));
        mign[m] = 1'b0;
      end
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    run = 1'b1;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion by cycle %0d", END_T);
    finish_run();
  end

  always @(negedge clk) begin
    if (run) begin
      for (int m = 0; m < 3; m++) check_mode(m);
      // stimulus for the coming edge
      req = 1'b0;
      if (tcnt == 3)       begin req = 1'b1; req_blk = 28'h123_4567; end
      else if (tcnt == 10) begin req = 1'b1; req_blk = 28'hABC_DEF0; end
      else if (tcnt == 30) begin req = 1'b1; req_blk = 28'h000_0001; end
      else if (tcnt >= 100 && tcnt < 400) begin
        req = 1'b1; req_blk = 28'(tcnt * 32'h0010_0101);
      end
      else if (tcnt == 450) begin req = 1'b1; req_blk = 28'hFFF_FFFF; end
      for (int m = 0; m < 3; m++) begin
        if (mk[m] == 0) begin
          if (req) begin mk[m] = 1; mblk[m] = req_blk; end
        end else begin
          if (req) mign[m] = 1'b1;
          mk[m] = (mk[m] == n_total(m)) ? 0 : mk[m] + 1;
        end
      end
      tcnt++;
      if (tcnt == END_T) finish_run();
    end
  end

endmodule